// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 double-precision operands and turns the outcome into a 2-bit condition code. The four possible codes are equal, less, greater and unordered. On each strobe the code is merged into one of four 2-bit condition fields of a 64-bit floating-point status register. A 2-bit index picks the field. The merge is a read-modify-write, so every other bit of the register keeps its value.

A mode bit chooses between two kinds of compare:
- A quiet compare raises the invalid-operation flag only when an operand is a signalling NaN.
- A signalling compare raises the flag for any NaN operand.

The ordering handles every class of operand. Zeros of either sign are equal. Subnormals are ordered exactly, with no flush to zero. Infinities of the same sign are equal.

Top module: `fp_cmp_cc`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the condition code is 11 (unordered).
- R2: `exc_invalid_o` is high for the one cycle after a strobe under these conditions. With `sig_mode_i`=1 it is high when either operand is a NaN. With `sig_mode_i`=0 it is high only when either operand is a signalling NaN (a NaN with fraction bit 51 clear). It is low in every other cycle.
- R3: Two zero operands give code 00 (equal) whatever their signs.
- R4: When exactly one operand is negative and they are not both zero, the code is 01 (less) if A is the negative one and 10 (greater) if B is.
- R5: For non-NaN operands of the same sign, magnitudes order as zero < finite < infinity. Code 01 means A is less and 10 means A is greater. The result is swapped when both operands are negative.
- R6: Two infinities of the same sign give code 00.
- R7: Two finite operands of the same sign are ordered by exact magnitude, subnormals included. Equal values give code 00.
- R8: The code goes to one field, chosen by `fld_sel_i`: index 0 writes status bits 11:10, index 1 writes 33:32, index 2 writes 35:34 and index 3 writes 37:36. All other status bits keep their value.
- R9: `status_o` changes one clock edge after a cycle with `valid_i` high and holds otherwise. Reset clears it, and `exc_invalid_o`, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Compare strobe |
| sig_mode_i | input | 1 | 1 = signalling compare, 0 = quiet compare |
| fld_sel_i | input | 2 | Target condition field index |
| op_a_i | input | 64 | Operand A, double precision |
| op_b_i | input | 64 | Operand B, double precision |
| status_o | output | 64 | Floating-point status register |
| exc_invalid_o | output | 1 | Invalid-operation flag for the last compare |

## Verification
The bound checker watches several properties on every cycle:
- the register holds when no strobe arrives;
- a strobe disturbs only the selected field;
- NaN operands yield unordered;
- zero pairs yield equal;
- the invalid flag follows both mode rules.

The sign, class and magnitude orderings of R4 to R7 are checked by the bench instead. It compares each result against an independent signed-key model, over directed corner cases and random operands that are biased toward zeros, subnormals, infinities and near-equal pairs.

// File: rtl/fp_cmp_cc.sv
module fp_cmp_cc #(
  parameter int SR_W   = 64,
  parameter int EXP_W  = 11,
  parameter int MAN_W  = 52,
  parameter int F0_LSB = 10,
  parameter int F1_LSB = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              sig_mode_i,
  input  logic [1:0]        fld_sel_i,
  input  logic [EXP_W+MAN_W:0] op_a_i,
  input  logic [EXP_W+MAN_W:0] op_b_i,
  output logic [SR_W-1:0]   status_o,
  output logic              exc_invalid_o
);
  localparam int MAG_W = EXP_W + MAN_W;
  localparam logic [1:0] CC_EQ = 2'b00;
  localparam logic [1:0] CC_LT = 2'b01;
  localparam logic [1:0] CC_GT = 2'b10;
  localparam logic [1:0] CC_UO = 2'b11;

  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             nan_a, nan_b, snan_a, snan_b, zero_a, zero_b;
  logic             any_nan, any_snan, raise_inv;
  logic [1:0]       cc;
  logic [SR_W-1:0]  fmask, fval;

  assign sa = op_a_i[MAG_W];
  assign sb = op_b_i[MAG_W];
  assign ma = op_a_i[MAG_W-1:0];
  assign mb = op_b_i[MAG_W-1:0];

  assign nan_a  = (&ma[MAG_W-1:MAN_W]) && (|ma[MAN_W-1:0]);
  assign nan_b  = (&mb[MAG_W-1:MAN_W]) && (|mb[MAN_W-1:0]);
  assign snan_a = nan_a && !ma[MAN_W-1];
  assign snan_b = nan_b && !mb[MAN_W-1];
  assign zero_a = ~|ma;
  assign zero_b = ~|mb;

  assign any_nan   = nan_a | nan_b;
  assign any_snan  = snan_a | snan_b;
  assign raise_inv = sig_mode_i ? any_nan : any_snan;

  always_comb begin
    if (any_nan)              cc = CC_UO;
    else if (zero_a && zero_b) cc = CC_EQ;
    else if (sa != sb)         cc = sa ? CC_LT : CC_GT;
    else if (ma == mb)         cc = CC_EQ;
    else if (ma < mb)          cc = sa ? CC_GT : CC_LT;
    else                       cc = sa ? CC_LT : CC_GT;
  end

  always_comb begin
    int lsb;
    lsb = (fld_sel_i == 2'd0) ? F0_LSB : F1_LSB + 2 * (int'(fld_sel_i) - 1);
    fmask = '0;
    fval  = '0;
    fmask[lsb +: 2] = 2'b11;
    fval[lsb +: 2]  = cc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o      <= '0;
      exc_invalid_o <= 1'b0;
    end else begin
      exc_invalid_o <= valid_i && raise_inv;
      if (valid_i) status_o <= (status_o & ~fmask) | fval;
    end
  end
endmodule

// File: rtl/fp_cmp_cc_chk.sv
module fp_cmp_cc_chk #(
  parameter int SR_W   = 64,
  parameter int EXP_W  = 11,
  parameter int MAN_W  = 52,
  parameter int F0_LSB = 10,
  parameter int F1_LSB = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  valid_i,
  input logic                  sig_mode_i,
  input logic [1:0]            fld_sel_i,
  input logic [EXP_W+MAN_W:0]  op_a_i,
  input logic [EXP_W+MAN_W:0]  op_b_i,
  input logic [SR_W-1:0]       status_o,
  input logic                  exc_invalid_o
);
  localparam int MAG_W = EXP_W + MAN_W;

  function automatic logic [SR_W-1:0] keep_mask(input logic [1:0] s);
    logic [SR_W-1:0] m;
    m = '1;
    case (s)
      2'd0: m[F0_LSB +: 2] = 2'b00;
      2'd1: m[F1_LSB +: 2] = 2'b00;
      2'd2: m[F1_LSB + 2 +: 2] = 2'b00;
      default: m[F1_LSB + 4 +: 2] = 2'b00;
    endcase
    return m;
  endfunction

  function automatic logic [1:0] pick(input logic [SR_W-1:0] r, input logic [1:0] s);
    case (s)
      2'd0: return r[F0_LSB +: 2];
      2'd1: return r[F1_LSB +: 2];
      2'd2: return r[F1_LSB + 2 +: 2];
      default: return r[F1_LSB + 4 +: 2];
    endcase
  endfunction

  function automatic logic is_nan(input logic [MAG_W:0] x);
    return (x[MAG_W-1:MAN_W] == '1) && (x[MAN_W-1:0] != '0);
  endfunction

  logic nan_in, qnan_only, zeros_in;
  assign nan_in    = is_nan(op_a_i) || is_nan(op_b_i);
  assign qnan_only = (!is_nan(op_a_i) || op_a_i[MAN_W-1]) && (!is_nan(op_b_i) || op_b_i[MAN_W-1]);
  assign zeros_in  = (op_a_i[MAG_W-1:0] == '0) && (op_b_i[MAG_W-1:0] == '0);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(status_o));

  a_r8_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> ((status_o & keep_mask($past(fld_sel_i))) ==
                 ($past(status_o) & keep_mask($past(fld_sel_i)))));

  a_r1_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && nan_in) |=> (pick(status_o, $past(fld_sel_i)) == 2'b11));

  a_r3_zeros_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && zeros_in) |=> (pick(status_o, $past(fld_sel_i)) == 2'b00));

  a_r2_signal_mode_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sig_mode_i && nan_in) |=> exc_invalid_o);

  a_r2_no_nan_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || !nan_in) |=> !exc_invalid_o);

  a_r2_quiet_qnan_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !sig_mode_i && qnan_only) |=> !exc_invalid_o);
endmodule

bind fp_cmp_cc fp_cmp_cc_chk #(
  .SR_W(SR_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .F0_LSB(F0_LSB), .F1_LSB(F1_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sig_mode_i(sig_mode_i),
  .fld_sel_i(fld_sel_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
  .status_o(status_o), .exc_invalid_o(exc_invalid_o)
);

// File: tb/fp_cmp_cc_test.sv
module fp_cmp_cc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        sig_mode_i = 1'b0;
  logic [1:0]  fld_sel_i = 2'd0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic [63:0] status_o;
  logic        exc_invalid_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [63:0] model_sr = '0;

  fp_cmp_cc uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sig_mode_i(sig_mode_i),
    .fld_sel_i(fld_sel_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .status_o(status_o), .exc_invalid_o(exc_invalid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] NTWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] MAXF  = 64'h7FEF_FFFF_FFFF_FFFF;

  function automatic bit nan_of(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0;
  endfunction

  function automatic logic signed [64:0] key_of(input logic [63:0] x);
    logic signed [64:0] m;
    m = {2'b00, x[62:0]};
    return x[63] ? -m : m;
  endfunction

  function automatic logic [1:0] ref_cc(input logic [63:0] a, input logic [63:0] b);
    if (nan_of(a) || nan_of(b)) return 2'b11;
    if (key_of(a) == key_of(b)) return 2'b00;
    return (key_of(a) < key_of(b)) ? 2'b01 : 2'b10;
  endfunction

  function automatic bit ref_inv(input logic [63:0] a, input logic [63:0] b, input bit sig);
    if (sig) return nan_of(a) || nan_of(b);
    return (nan_of(a) && !a[51]) || (nan_of(b) && !b[51]);
  endfunction

  function automatic int lsb_of(input logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 32;
      2'd2: return 34;
      default: return 36;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cmp(input string req, input logic [63:0] a, input logic [63:0] b,
                     input bit sig, input logic [1:0] sel);
    logic [1:0] cc;
    bit inv;
    @(negedge clk);
    op_a_i = a; op_b_i = b; sig_mode_i = sig; fld_sel_i = sel; valid_i = 1'b1;
    cc  = ref_cc(a, b);
    inv = ref_inv(a, b, sig);
    model_sr[lsb_of(sel) +: 2] = cc;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, status_o, model_sr);
    check({req, " invalid flag"}, {63'd0, exc_invalid_o}, {63'd0, inv});
  endtask

  function automatic logic [63:0] rnd_op();
    logic [63:0] x;
    x = {$urandom, $urandom};
    case ($urandom_range(0, 5))
      0: x[62:52] = 11'h000;
      1: x[62:52] = 11'h7FF;
      2: x[62:0] = '0;
      3: x[62:52] = 11'h7FE;
      default: ;
    endcase
    if ($urandom_range(0, 3) == 0) x[51:0] = '0;
    return x;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset status", status_o, '0);
    check("R9 reset flag", {63'd0, exc_invalid_o}, '0);

    cmp("R1 quiet NaN quiet mode", QNAN, PONE, 1'b0, 2'd0);
    cmp("R2 signalling NaN quiet mode", PONE, SNAN, 1'b0, 2'd1);
    cmp("R2 quiet NaN signalling mode", QNAN, QNAN, 1'b1, 2'd2);
    cmp("R3 plus zero vs minus zero", PZERO, NZERO, 1'b1, 2'd3);
    cmp("R4 negative A", NONE, PONE, 1'b0, 2'd0);
    cmp("R4 negative B", PZERO, NTWO, 1'b0, 2'd1);
    cmp("R5 zero below finite", PZERO, PONE, 1'b0, 2'd2);
    cmp("R5 negatives swap", NINF, NONE, 1'b0, 2'd3);
    cmp("R6 minus inf pair", NINF, NINF, 1'b1, 2'd1);
    cmp("R6 plus inf pair", PINF, PINF, 1'b0, 2'd0);
    cmp("R5 max finite below inf", MAXF, PINF, 1'b0, 2'd2);
    cmp("R7 subnormal order", 64'h1, 64'h2, 1'b0, 2'd3);
    cmp("R7 negative subnormal order", 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0002, 1'b0, 2'd1);
    cmp("R7 equal finite", NTWO, NTWO, 1'b0, 2'd2);
    cmp("R7 negative finite swap", NTWO, NONE, 1'b1, 2'd0);

    @(negedge clk);
    op_a_i = QNAN; op_b_i = SNAN; sig_mode_i = 1'b1; fld_sel_i = 2'd3;
    repeat (4) @(negedge clk);
    check("R9 idle hold", status_o, model_sr);
    check("R2 idle flag low", {63'd0, exc_invalid_o}, '0);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      a = rnd_op();
      case ($urandom_range(0, 3))
        0: b = a;
        1: b = a ^ 64'h8000_0000_0000_0000;
        2: b = a + 64'd1;
        default: b = rnd_op();
      endcase
      cmp("R8 random compare", a, b, 1'($urandom), 2'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule